// File: doc/BRIEF.md
# Sequential Radix-2 Booth Multiplier

This block multiplies two signed two's complement operands of WIDTH bits and returns their full 2*WIDTH-bit signed product. It works one multiplier bit per clock. Plain shift-and-add would add the multiplicand once for every 1 bit. This block instead looks at each multiplier bit together with the bit below it. It subtracts the multiplicand where a run of ones begins and adds it back just past the end of the run. One iteration takes one clock, and a complete multiply takes WIDTH iterations.

The surrounding logic presents both operands and pulses or holds `start_i` while the block is idle. The block captures the operands on that edge and raises `busy_o`. When the product is ready it pulses `done_o` for one cycle with the result on `product_o`. The product stays on `product_o` until the next multiply completes. While the block is busy, `start_i` and the operand ports have no effect.

Top module: `booth_seq_mult`

## Requirements
- R1: After a clock edge with `rst` high, `busy_o` and `done_o` are 0 and `product_o` is 0.
- R2: A clock edge with `start_i` high while `busy_o` is 0 captures `a_i` and `b_i` and sets `busy_o`. `busy_o` stays high for exactly WIDTH cycles. It falls on the WIDTH-th following edge, which is also the edge that raises `done_o`.
- R3: When `done_o` is high, `product_o` equals the signed product of the captured operands, each read as WIDTH-bit two's complement. The product is 2*WIDTH bits wide. This holds for the most negative operand as well: with WIDTH=16, -32768 times -32768 gives 0x40000000.
- R4: `done_o` is high for exactly one cycle per accepted start.
- R5: While `busy_o` is high, `start_i` is ignored. Changes on `a_i` and `b_i` during that time do not alter the result in progress.
- R6: `product_o` changes only on the edge that raises `done_o`. It holds its value at all other times.
- R7: The multiplier is scanned from bit 0 upward, with an implicit 0 below bit 0. For each pair (current bit, lower bit), 1/0 subtracts the multiplicand at that bit's weight and 0/1 adds it. Pairs 0/0 and 1/1 leave the sum unchanged. Multipliers made of long runs of ones, such as all ones, 0x00FF and 0x0FF0, and alternating patterns such as 0x5555 and 0xAAAA, all give the exact product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Request a multiply; accepted only while idle |
| a_i | input | WIDTH | Multiplicand, signed |
| b_i | input | WIDTH | Multiplier, signed |
| busy_o | output | 1 | Multiply in progress |
| done_o | output | 1 | One-cycle pulse: product valid and newly updated |
| product_o | output | 2*WIDTH | Signed product, held until the next completion |

## Verification
The bound checker checks the handshake on every cycle. It checks that a start accepted while idle raises busy, that busy lasts exactly WIDTH cycles before done, and that done lasts one cycle. It also checks that the product is frozen between completions and equals the signed product of the operands captured at acceptance. Whether the Booth recoding is right for particular bit patterns only shows up in the bench's scenarios. These scenarios cover runs of ones, alternating bits, the most negative value on either side, and random operands. In the same scenarios, operands are changed and start is raised in the middle of a multiply. The bench's cycle-by-cycle model has to agree on busy, done and product throughout.

// File: rtl/booth_mult_pkg.sv
package booth_mult_pkg;

  // Action taken on the running sum for one scanned multiplier bit.
  typedef enum logic [1:0] {
    BOOTH_KEEP = 2'd0,
    BOOTH_ADD  = 2'd1,
    BOOTH_SUB  = 2'd2
  } booth_act_e;

  // Radix-2 recoding of (current bit, bit below it).
  function automatic booth_act_e booth_decode(input logic cur_bit, input logic low_bit);
    booth_act_e act;
    unique case ({cur_bit, low_bit})
      2'b10:   act = BOOTH_SUB;   // a run of ones starts here
      2'b01:   act = BOOTH_ADD;   // a run of ones ended just below
      default: act = BOOTH_KEEP;  // inside a run of zeros or of ones
    endcase
    return act;
  endfunction

endpackage

// File: rtl/booth_recode.sv
module booth_recode
  import booth_mult_pkg::*;
(
  input  logic       cur_bit_i,
  input  logic       low_bit_i,
  output booth_act_e act_o
);

  always_comb begin
    act_o = booth_decode(cur_bit_i, low_bit_i);
  end

endmodule

// File: rtl/booth_addsub.sv
module booth_addsub
  import booth_mult_pkg::*;
#(
  parameter int W = 17
) (
  input  logic [W-1:0] acc_i,
  input  logic [W-1:0] mcand_i,
  input  booth_act_e   act_i,
  output logic [W-1:0] sum_o
);

  logic         do_sub;
  logic         do_op;
  logic [W-1:0] operand;

  always_comb begin
    do_sub  = (act_i == BOOTH_SUB);
    do_op   = (act_i != BOOTH_KEEP);
    // Subtraction is an add of the inverted operand with a carry in.
    operand = do_op ? (mcand_i ^ {W{do_sub}}) : '0;
    sum_o   = acc_i + operand + W'(do_sub);
  end

endmodule

// File: rtl/booth_seq_ctrl.sv
module booth_seq_ctrl #(
  parameter int ITERS = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic busy_o,
  output logic load_o,
  output logic step_o,
  output logic last_o
);

  localparam int CW = (ITERS > 1) ? $clog2(ITERS) : 1;
  localparam logic [CW-1:0] LAST_IDX = CW'(ITERS - 1);

  logic          busy_q;
  logic [CW-1:0] iter_q;

  always_comb begin
    load_o = !busy_q && start_i;
    step_o = busy_q;
    last_o = busy_q && (iter_q == LAST_IDX);
    busy_o = busy_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      iter_q <= '0;
    end else if (busy_q) begin
      iter_q <= iter_q + 1'b1;
      if (iter_q == LAST_IDX) begin
        busy_q <= 1'b0;
      end
    end else if (start_i) begin
      busy_q <= 1'b1;
      iter_q <= '0;
    end
  end

endmodule

// File: rtl/booth_seq_mult.sv
module booth_seq_mult
  import booth_mult_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic [WIDTH-1:0]   a_i,
  input  logic [WIDTH-1:0]   b_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [2*WIDTH-1:0] product_o
);

  localparam int AW = WIDTH + 1;       // guarded sum width
  localparam int PW = 2 * WIDTH;       // product width
  localparam int SW = AW + WIDTH;      // sum plus multiplier register

  logic load, step, last, busy;

  // Datapath state
  logic [AW-1:0]    mcand_q;           // sign-extended multiplicand
  logic [AW-1:0]    acc_q;             // upper part of product register
  logic [WIDTH-1:0] mplr_q;            // lower part, multiplier being consumed
  logic             low_q;             // bit below the current multiplier bit
  logic             done_q;
  logic [PW-1:0]    prod_q;

  booth_act_e    act;
  logic [AW-1:0] sum;
  logic [SW-1:0] joined;
  logic [SW-1:0] shifted;

  booth_seq_ctrl #(.ITERS(WIDTH)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .busy_o  (busy),
    .load_o  (load),
    .step_o  (step),
    .last_o  (last)
  );

  booth_recode u_recode (
    .cur_bit_i (mplr_q[0]),
    .low_bit_i (low_q),
    .act_o     (act)
  );

  booth_addsub #(.W(AW)) u_addsub (
    .acc_i   (acc_q),
    .mcand_i (mcand_q),
    .act_i   (act),
    .sum_o   (sum)
  );

  // Arithmetic right shift of {sum, multiplier}
  always_comb begin
    joined  = {sum, mplr_q};
    shifted = {sum[AW-1], joined[SW-1:1]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mcand_q <= '0;
      acc_q   <= '0;
      mplr_q  <= '0;
      low_q   <= 1'b0;
    end else if (load) begin
      mcand_q <= {a_i[WIDTH-1], a_i};
      acc_q   <= '0;
      mplr_q  <= b_i;
      low_q   <= 1'b0;
    end else if (step) begin
      acc_q  <= shifted[SW-1:WIDTH];
      mplr_q <= shifted[WIDTH-1:0];
      low_q  <= mplr_q[0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q <= 1'b0;
      prod_q <= '0;
    end else begin
      done_q <= last;
      if (last) begin
        prod_q <= shifted[PW-1:0];
      end
    end
  end

  assign busy_o    = busy;
  assign done_o    = done_q;
  assign product_o = prod_q;

endmodule

// File: rtl/booth_seq_mult_chk.sv
module booth_seq_mult_chk #(
  parameter int WIDTH = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               start_i,
  input logic [WIDTH-1:0]   a_i,
  input logic [WIDTH-1:0]   b_i,
  input logic               busy_o,
  input logic               done_o,
  input logic [2*WIDTH-1:0] product_o
);

  logic [WIDTH-1:0]          cap_a, cap_b;
  logic [31:0]               busy_run;
  logic signed [2*WIDTH-1:0] want_prod;

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_a    <= '0;
      cap_b    <= '0;
      busy_run <= '0;
    end else begin
      if (!busy_o && start_i) begin
        cap_a <= a_i;
        cap_b <= b_i;
      end
      busy_run <= busy_o ? busy_run + 1 : '0;
    end
  end

  always_comb begin
    want_prod = $signed({{WIDTH{cap_a[WIDTH-1]}}, cap_a}) *
                $signed({{WIDTH{cap_b[WIDTH-1]}}, cap_b});
  end

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (!busy_o && !done_o && product_o == '0));

  p_accept_r2: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && start_i) |=> busy_o);

  p_busy_len_r2: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!busy_o && busy_run == 32'(WIDTH)));

  p_product_r3: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (product_o == want_prod));

  p_done_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  p_no_restart_r5: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> (busy_run <= 32'(WIDTH)));

  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!done_o && !$past(rst)) |-> $stable(product_o));

endmodule

bind booth_seq_mult booth_seq_mult_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/booth_seq_mult_test.sv
`timescale 1ns/1ps
module booth_seq_mult_test;

  localparam int W = 16;
  localparam int PW = 2 * W;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start_i = 1'b0;
  logic [W-1:0]  a_i = '0;
  logic [W-1:0]  b_i = '0;
  logic          busy_o, done_o;
  logic [PW-1:0] product_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;   // 125 MHz

  booth_seq_mult #(.WIDTH(W)) uut (
    .clk(clk), .rst(rst), .start_i(start_i), .a_i(a_i), .b_i(b_i),
    .busy_o(busy_o), .done_o(done_o), .product_o(product_o)
  );

  // Behavioural reference: cycle-accurate handshake with integer arithmetic.
  logic          m_busy = 0, m_done = 0;
  logic [PW-1:0] m_prod = '0, m_pend = '0;
  int            m_left = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_done = 0; m_prod = '0; m_left = 0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        m_left = m_left - 1;
        if (m_left == 0) begin
          m_busy = 0; m_done = 1; m_prod = m_pend;
        end
      end else if (start_i) begin
        m_busy = 1;
        m_left = W;
        m_pend = $signed({{W{a_i[W-1]}}, a_i}) * $signed({{W{b_i[W-1]}}, b_i});
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Compare against the model on every cycle, away from the active edge.
  always @(negedge clk) begin
    if (!rst && !finished) begin
      check(busy_o === m_busy, "R2/R5 busy", 64'(busy_o), 64'(m_busy));
      check(done_o === m_done, "R4 done", 64'(done_o), 64'(m_done));
      check(product_o === m_prod, "R3/R6 product", 64'(product_o), 64'(m_prod));
    end
  end

  // One multiply; optionally disturb start and operands while busy (R5).
  task automatic run_mult(input logic [W-1:0] a, input logic [W-1:0] b,
                          input bit disturb, input string tag);
    logic [PW-1:0] exp;
    bit seen = 0;
    exp = $signed({{W{a[W-1]}}, a}) * $signed({{W{b[W-1]}}, b});
    @(negedge clk);
    a_i = a; b_i = b; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int i = 0; i < 4 * W && !seen; i++) begin
      if (disturb && i == 2) begin
        start_i = 1'b1; a_i = ~a; b_i = b + 16'd3;
      end else if (disturb && i == 4) begin
        start_i = 1'b0;
      end
      @(negedge clk);
      if (done_o) seen = 1;
    end
    start_i = 1'b0;
    check(seen, {tag, " done seen"}, 64'(seen), 64'd1);
    check(product_o === exp, tag, 64'(product_o), 64'(exp));
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check(busy_o === 1'b0 && done_o === 1'b0, "R1 flags", {62'd0, busy_o, done_o}, 64'd0);
    check(product_o === '0, "R1 product", 64'(product_o), 64'd0);
    rst = 1'b0;

    run_mult(16'd0, 16'd0, 0, "R3 zero");
    run_mult(16'd1, 16'd1, 0, "R3 one");
    run_mult(16'hFFFF, 16'hFFFF, 0, "R3 minus one squared");
    run_mult(16'h8000, 16'h8000, 0, "R3 most negative squared");
    run_mult(16'h8000, 16'h7FFF, 0, "R3 min times max");
    run_mult(16'h7FFF, 16'h7FFF, 0, "R3 max squared");
    run_mult(16'h8000, 16'hFFFF, 0, "R3 min times minus one");
    run_mult(16'h1234, 16'h8000, 0, "R3 multiplier most negative");
    run_mult(16'd1234, 16'h00FF, 0, "R7 low run of ones");
    run_mult(16'hFFF9, 16'h0FF0, 0, "R7 inner run of ones");
    run_mult(16'h0123, 16'h5555, 0, "R7 alternating 0x5555");
    run_mult(16'hBEEF, 16'hAAAA, 0, "R7 alternating 0xAAAA");
    run_mult(16'h2345, 16'h0077, 1, "R5 start and operands changed while busy");

    // R2/R4/R5: start held high across back-to-back multiplies
    @(negedge clk);
    a_i = 16'h0F0F; b_i = 16'hF00D; start_i = 1'b1;
    repeat (3 * (W + 1) + 2) @(negedge clk);
    start_i = 1'b0;
    repeat (W + 3) @(negedge clk);

    for (int k = 0; k < 40; k++) begin
      run_mult(16'($urandom), 16'($urandom), (k % 5) == 0, "R3 random");
    end

    repeat (4) @(negedge clk);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule